// File: doc/BRIEF.md
# Lockable Dual Comparator Control Unit

This block is the digital side of a pair of analog comparators. Software reaches two 32-bit control/status words over a small register bus. Each word sets enable, speed/power mode, hysteresis, the plus and minus input selections, output polarity, a blanking source and two shared reference-ladder enables. The block drives these settings to the analog macro, and it conditions the two raw comparator decisions into outputs for timer break inputs and an interrupt controller.

Each raw decision is first corrected for polarity. It is then ANDed with the inverse of a timer compare signal that software selects as a blanking window. The path from the stored control bits to the conditioned outputs has no register in it, so the outputs keep following the comparators while the bus clock is stopped. Each conditioned output also passes through a synchroniser and a two-state edge machine. The machine has the states `EDG_LOW` and `EDG_HIGH`. The transition LOW→HIGH emits a one-cycle rise strobe, HIGH→LOW emits a one-cycle fall strobe, and otherwise the state is held.

Each word has a sticky lock bit. Once software sets it, the whole word, the lock bit included, ignores writes until reset. A safety loop built on the comparators therefore cannot be reprogrammed by a stray store.

Top module: `dual_cmp_ctrl`

## Requirements
- R1: After reset both control words read 0x0000_0000, and every conditioned output, strobe and analog control output is 0.
- R2: When bit 31 (lock) of a word is 1, any write to that word is dropped and the lock stays 1 until reset. The other word remains writable, and reset clears the lock.
- R3: The word at byte address 0 keeps only the bits set in 0x80DF_80FD and the word at address 4 only those in 0x80DF_82FD. Bit 30 is never stored. Other addresses read 0 and ignore writes.
- R4: Bit 30 of a word reads as EN (bit 0) AND (raw decision XOR polarity bit 15).
- R5: Bits 20:18 pick the blanking window. For channel 0, 001 selects blank_in[0] and 010 selects blank_in[1]. For channel 1, 100 selects blank_in[2]. Every other code means no blanking.
- R6: cmp_out[i] equals the bit-30 value of word i ANDed with the inverse of its selected blanking signal, so it is 0 whenever EN is 0. The path is combinational.
- R7: win_tie equals bit 9 of the word at address 4. Bit 9 of the word at address 0 has no effect.
- R8: scaler_en is the OR of bit 23 of both words, and bridge_en is the OR of bit 22 of both words. When scaler_en=1 and bridge_en=0, minus-select codes 000, 001 and 010 are driven out as 011. All other codes pass unchanged.
- R9: Channel i drives ch_en_o[i] from bit 0, ch_pwr_o[2i+1:2i] from bits 3:2, ch_hyst_o[2i+1:2i] from bits 17:16, ch_inp_o[i] from bit 7 and ch_inm_o[3i+2:3i] from bits 6:4.
- R10: Each 0→1 change of cmp_out[i] gives exactly one single-cycle pulse on ev_rise[i], and each 1→0 change gives one on ev_fall[i]. The pulse comes after a two-stage synchroniser, and rise and fall are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| raw_in | input | 2 | Raw comparator decisions |
| blank_in | input | 3 | Timer compare windows used for blanking |
| cmp_out | output | 2 | Conditioned outputs to timer break and interrupt logic |
| ev_rise | output | 2 | Rising-edge strobes |
| ev_fall | output | 2 | Falling-edge strobes |
| ch_en_o | output | 2 | Comparator enables |
| ch_pwr_o | output | 4 | Power modes, 2 bits per channel |
| ch_hyst_o | output | 4 | Hysteresis levels, 2 bits per channel |
| ch_inp_o | output | 2 | Plus-input selects |
| ch_inm_o | output | 6 | Effective minus-input selects, 3 bits per channel |
| win_tie | output | 1 | Ties the channel 1 plus input to the channel 0 plus input |
| scaler_en | output | 1 | Reference scaler enable |
| bridge_en | output | 1 | Scaler resistor bridge enable |

## Verification
The bench writes a locked word with zeros. A design that left a path to clear the lock would read back the old value changed. It also confirms that the neighbouring word still accepts writes and that reset releases the lock. It writes all ones except the lock to find a stored reserved bit or a stored status bit. It drives every blanking window under codes that are reserved for one channel but valid for the other, which exposes a decoder shared across channels. It also checks that fractional reference codes collapse to the full reference only when the scaler is on and the bridge is off, and it counts strobes per edge to catch missing or doubled pulses.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
    localparam int NCH     = 2;
    localparam int NBLANK  = 3;
    localparam int DW      = 32;
    localparam int LOCK_B  = 31;
    localparam int VAL_B   = 30;
    localparam int SCAL_B  = 23;
    localparam int BRG_B   = 22;
    localparam int BLK_LO  = 18;
    localparam int HYS_LO  = 16;
    localparam int POL_B   = 15;
    localparam int WIN_B   = 9;
    localparam int INP_B   = 7;
    localparam int INM_LO  = 4;
    localparam int PWR_LO  = 2;
    localparam int EN_B    = 0;

    localparam logic [DW-1:0] MASK_CH0 = 32'h80DF_80FD;
    localparam logic [DW-1:0] MASK_CH1 = 32'h80DF_82FD;

    typedef enum logic {EDG_LOW, EDG_HIGH} edge_st_t;

    function automatic logic [DW-1:0] wmask(input int ch);
        return (ch == 1) ? MASK_CH1 : MASK_CH0;
    endfunction

    // one-hot pick of the blanking window for a channel and code
    function automatic logic [NBLANK-1:0] blank_pick(input int ch, input logic [2:0] code);
        logic [NBLANK-1:0] r;
        r = '0;
        if (ch == 0) begin
            if (code == 3'b001) r = 3'b001;
            if (code == 3'b010) r = 3'b010;
        end else begin
            if (code == 3'b100) r = 3'b100;
        end
        return r;
    endfunction
endpackage

// File: rtl/cmp_reg.sv
module cmp_reg
    import cmp_pkg::*;
#(
    parameter logic [DW-1:0] WMASK = MASK_CH0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en && !q[LOCK_B])
            q <= wdata & WMASK;
    end

    assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q[LOCK_B] |=> q[LOCK_B]);
    assert_lock_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q[LOCK_B] |=> $stable(q));
endmodule

// File: rtl/cmp_cond.sv
module cmp_cond
    import cmp_pkg::*;
#(
    parameter int CH = 0
) (
    input  logic              en,
    input  logic              pol,
    input  logic [2:0]        blk_code,
    input  logic [NBLANK-1:0] blank_in,
    input  logic              raw,
    output logic              value,
    output logic              cond
);
    logic blank_hit;

    always_comb begin
        value     = en & (raw ^ pol);
        blank_hit = |(blank_in & blank_pick(CH, blk_code));
        cond      = value & ~blank_hit;
    end
endmodule

// File: rtl/cmp_edge.sv
module cmp_edge
    import cmp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    edge_st_t               st_q, st_d;
    logic                   s_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
    end
    assign s_in = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= EDG_LOW;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        rise = 1'b0;
        fall = 1'b0;
        unique case (st_q)
            EDG_LOW:  if (s_in)  begin st_d = EDG_HIGH; rise = 1'b1; end
            EDG_HIGH: if (!s_in) begin st_d = EDG_LOW;  fall = 1'b1; end
            default:  st_d = EDG_LOW;
        endcase
    end

    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));
    assert_rise_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    assert_fall_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/dual_cmp_ctrl.sv
module dual_cmp_ctrl
    import cmp_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NCH-1:0]    raw_in,
    input  logic [NBLANK-1:0] blank_in,
    output logic [NCH-1:0]    cmp_out,
    output logic [NCH-1:0]    ev_rise,
    output logic [NCH-1:0]    ev_fall,
    output logic [NCH-1:0]    ch_en_o,
    output logic [2*NCH-1:0]  ch_pwr_o,
    output logic [2*NCH-1:0]  ch_hyst_o,
    output logic [NCH-1:0]    ch_inp_o,
    output logic [3*NCH-1:0]  ch_inm_o,
    output logic              win_tie,
    output logic              scaler_en,
    output logic              bridge_en
);
    logic [DW-1:0]  csr   [NCH];
    logic [NCH-1:0] value;
    logic [NCH-1:0] scal_v, brg_v;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(g * 4);
        logic       wr_hit;
        logic [2:0] inm_raw;

        assign wr_hit = bus_wr && (bus_addr == CH_ADDR);

        cmp_reg #(.WMASK(wmask(g))) u_reg (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_hit),
            .wdata(bus_wdata), .q(csr[g])
        );

        cmp_cond #(.CH(g)) u_cond (
            .en(csr[g][EN_B]), .pol(csr[g][POL_B]),
            .blk_code(csr[g][BLK_LO+:3]), .blank_in(blank_in),
            .raw(raw_in[g]), .value(value[g]), .cond(cmp_out[g])
        );

        cmp_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk(clk), .rst_n(rst_n), .din(cmp_out[g]),
            .rise(ev_rise[g]), .fall(ev_fall[g])
        );

        assign inm_raw          = csr[g][INM_LO+:3];
        assign ch_en_o[g]       = csr[g][EN_B];
        assign ch_pwr_o[2*g+:2] = csr[g][PWR_LO+:2];
        assign ch_hyst_o[2*g+:2]= csr[g][HYS_LO+:2];
        assign ch_inp_o[g]      = csr[g][INP_B];
        assign ch_inm_o[3*g+:3] = (scaler_en && !bridge_en && inm_raw < 3'b011)
                                  ? 3'b011 : inm_raw;
        assign scal_v[g]        = csr[g][SCAL_B];
        assign brg_v[g]         = csr[g][BRG_B];

        assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en_o[g] |-> !cmp_out[g]);
        assert_out_le_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_out[g] |-> bus_rdata[VAL_B] || (bus_addr != CH_ADDR));
    end

    assign scaler_en = |scal_v;
    assign bridge_en = |brg_v;
    assign win_tie   = csr[1][WIN_B];

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == ADDR_W'(i * 4)) begin
                bus_rdata        = csr[i];
                bus_rdata[VAL_B] = value[i];
            end
        end
    end

    assert_no_status_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !csr[0][VAL_B] && !csr[1][VAL_B]);
endmodule

// File: tb/sim_dual_cmp_ctrl.sv
module sim_dual_cmp_ctrl;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  raw_in = '0;
    logic [2:0]  blank_in = '0;
    logic [1:0]  cmp_out, ev_rise, ev_fall, ch_en_o, ch_inp_o;
    logic [3:0]  ch_pwr_o, ch_hyst_o;
    logic [5:0]  ch_inm_o;
    logic        win_tie, scaler_en, bridge_en;

    int checks = 0;
    int errors = 0;
    int n_rise = 0;
    int n_fall = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dual_cmp_ctrl u0 (.*);

    always @(negedge clk) begin
        if (ev_rise[0]) n_rise++;
        if (ev_fall[0]) n_fall++;
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd_chk(string tag, logic [2:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 chk(tag, bus_rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        raw_in = 0; blank_in = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic t_reset();
        rd_chk("R1 word0", 3'd0, 32'h0);
        rd_chk("R1 word1", 3'd4, 32'h0);
        chk("R1 outputs", {cmp_out, ev_rise, ev_fall, ch_en_o, win_tie, scaler_en, bridge_en},
            '0);
        chk("R1 fields", {ch_pwr_o, ch_hyst_o, ch_inm_o, ch_inp_o}, '0);
    endtask

    task automatic t_fields();
        wr(3'd0, 32'h0003_00E9);
        wr(3'd4, 32'h0001_0055);
        #1;
        chk("R9 en", ch_en_o, 2'b11);
        chk("R9 pwr", ch_pwr_o, 4'b0110);
        chk("R9 hyst", ch_hyst_o, 4'b0111);
        chk("R9 inp", ch_inp_o, 2'b01);
        chk("R9 inm", ch_inm_o, 6'b101110);
    endtask

    task automatic t_value();
        wr(3'd0, 32'h0000_0001);
        raw_in[0] = 1; #1;
        rd_chk("R4 value pol0", 3'd0, 32'h4000_0001);
        chk("R6 out pass", cmp_out[0], 1'b1);
        wr(3'd0, 32'h0000_8001); #1;
        rd_chk("R4 value pol1", 3'd0, 32'h0000_8001);
        chk("R6 out inverted", cmp_out[0], 1'b0);
        raw_in[0] = 0; #1;
        chk("R6 out inv low raw", cmp_out[0], 1'b1);
        wr(3'd0, 32'h0000_8000); #1;
        rd_chk("R4 value en0", 3'd0, 32'h0000_8000);
        chk("R6 out en0", cmp_out[0], 1'b0);
    endtask

    task automatic t_blank();
        raw_in = 2'b11;
        wr(3'd0, 32'h0004_0001);
        blank_in = 3'b001; #1; chk("R5 ch0 code001 win0", cmp_out[0], 1'b0);
        blank_in = 3'b110; #1; chk("R5 ch0 code001 other", cmp_out[0], 1'b1);
        wr(3'd0, 32'h0008_0001);
        blank_in = 3'b010; #1; chk("R5 ch0 code010 win1", cmp_out[0], 1'b0);
        wr(3'd0, 32'h000C_0001);
        blank_in = 3'b111; #1; chk("R5 ch0 code011 none", cmp_out[0], 1'b1);
        wr(3'd0, 32'h0010_0001);
        #1; chk("R5 ch0 code100 none", cmp_out[0], 1'b1);
        wr(3'd4, 32'h0010_0001);
        blank_in = 3'b100; #1; chk("R5 ch1 code100 win2", cmp_out[1], 1'b0);
        wr(3'd4, 32'h0004_0001);
        blank_in = 3'b011; #1; chk("R5 ch1 code001 none", cmp_out[1], 1'b1);
        blank_in = 0; raw_in = 0;
    endtask

    task automatic t_reserved();
        do_reset();
        wr(3'd2, 32'hFFFF_FFFF);
        rd_chk("R3 unmapped read", 3'd2, 32'h0);
        rd_chk("R3 unmapped write word0", 3'd0, 32'h0);
        rd_chk("R3 unmapped write word1", 3'd4, 32'h0);
        wr(3'd0, 32'h7FFF_FFFF);
        wr(3'd4, 32'h7FFF_FFFF);
        rd_chk("R3 mask word0", 3'd0, 32'h40DF_80FD);
        rd_chk("R3 mask word1", 3'd4, 32'h40DF_82FD);
    endtask

    task automatic t_window();
        do_reset();
        wr(3'd0, 32'h0000_0200); #1;
        chk("R7 word0 bit9 no effect", win_tie, 1'b0);
        wr(3'd4, 32'h0000_0200); #1;
        chk("R7 word1 bit9", win_tie, 1'b1);
        wr(3'd4, 32'h0); #1;
        chk("R7 cleared", win_tie, 1'b0);
    endtask

    task automatic t_scaler();
        do_reset();
        wr(3'd0, 32'h0080_0010); #1;
        chk("R8 scaler or", {scaler_en, bridge_en}, 2'b10);
        chk("R8 sub to full", ch_inm_o[2:0], 3'b011);
        wr(3'd4, 32'h0040_0040); #1;
        chk("R8 bridge or", {scaler_en, bridge_en}, 2'b11);
        chk("R8 fraction kept", ch_inm_o[2:0], 3'b001);
        chk("R8 dac code kept", ch_inm_o[5:3], 3'b100);
        wr(3'd4, 32'h0000_0040); #1;
        chk("R8 dac code no sub", ch_inm_o[5:3], 3'b100);
    endtask

    task automatic t_edges();
        do_reset();
        wr(3'd0, 32'h0000_0001);
        n_rise = 0; n_fall = 0;
        raw_in[0] = 1;
        repeat (6) @(negedge clk);
        chk("R10 one rise", n_rise, 1);
        chk("R10 no fall", n_fall, 0);
        raw_in[0] = 0;
        repeat (6) @(negedge clk);
        chk("R10 one fall", n_fall, 1);
        chk("R10 rise unchanged", n_rise, 1);
    endtask

    task automatic t_lock();
        do_reset();
        wr(3'd0, 32'h8000_0001);
        wr(3'd0, 32'h0000_0000);
        rd_chk("R2 locked hold", 3'd0, 32'h8000_0001);
        wr(3'd0, 32'h7FFF_FFFF);
        rd_chk("R2 locked ignore", 3'd0, 32'h8000_0001);
        wr(3'd4, 32'h0000_0001);
        rd_chk("R2 other word free", 3'd4, 32'h0000_0001);
        do_reset();
        rd_chk("R2 reset clears lock", 3'd0, 32'h0);
        wr(3'd0, 32'h0000_0004);
        rd_chk("R2 writable after reset", 3'd0, 32'h0000_0004);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_value();
        t_blank();
        t_reserved();
        t_window();
        t_scaler();
        t_edges();
        t_lock();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule